// File: doc/BRIEF.md
# Next-PC Sequencer with One-Slot Delayed Redirect

This block owns the program counter of a 32-bit fixed-width RISC core whose control transfers are delayed by one instruction. Every cycle the decoder presents the control class of the instruction now at the PC, together with its immediate field and the two register operand values. The block decides whether that instruction transfers control and computes where to. A taken transfer does not change the very next fetch: the instruction that follows it in memory is always executed, and only the fetch after that one goes to the target.

The sequencer holds the target in a one-entry pending register for exactly one cycle and then loads it into the PC. Conditional branches are PC-relative, measured from the address of the slot instruction. Region jumps keep the top nibble of the jump's own PC. Register jumps take the operand value. The call form also reports a return address for the register file. A register jump with a target that is not word aligned raises a one-cycle flag, and the PC takes the target with its two low bits forced to zero, so the PC is always word aligned.

Top module: `pc_sequencer`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `pc_o` equals RESET_PC (default 32'h0000_1000), `link_we` and `tgt_misalign` are 0, and no redirect is pending.
- R2: When no redirect is pending, the PC of the next cycle is the current PC plus 4; bits 1:0 of `pc_o` are 0 in every cycle.
- R3: `ctl_kind` encodes 0 none, 1 equal-branch, 2 not-equal-branch, 3 branch-if-rs-less-or-equal-zero, 4 branch-if-rs-greater-than-zero, 5 region jump, 6 jump-and-link, 7 register jump. A taken branch at PC P has target P + 4 + (sign-extended `ctl_imm[15:0]` shifted left by 2).
- R4: Equal-branch is taken when `rs_val` == `rt_val`, not-equal-branch when they differ; the two zero tests treat `rs_val` as signed two's complement. A branch that is not taken behaves like kind 0.
- R5: A region jump at PC P has target {P[31:28], `ctl_imm[25:0]`, 2'b00}.
- R6: A jump-and-link at PC P redirects like a region jump and, in the following cycle, drives `link_we` = 1, `link_idx` = 31 and `link_val` = P + 8.
- R7: A register jump has target {`rs_val`[31:2], 2'b00}; when `rs_val`[1:0] is not 00, `tgt_misalign` is 1 in the following cycle.
- R8: After a taken transfer at PC P, `pc_o` is P + 4 in the next cycle and the target in the cycle after.
- R9: A taken transfer sitting in a delay slot does not disturb the pending redirect: the PC first loads the earlier target and then, one cycle later, the slot instruction's own target.
- R10: `link_we` and `tgt_misalign` are 0 in any cycle that does not follow, respectively, a jump-and-link or a misaligned register jump.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_kind | input | 3 | Control class of the instruction at `pc_o` |
| ctl_imm | input | 26 | Immediate field; low 16 bits for branches, all 26 for jumps |
| rs_val | input | 32 | First register operand value |
| rt_val | input | 32 | Second register operand value |
| pc_o | output | 32 | Address of the instruction executing this cycle |
| link_we | output | 1 | Return-address write enable |
| link_idx | output | 5 | Destination register of the return address |
| link_val | output | 32 | Return address |
| tgt_misalign | output | 1 | Register-jump target had nonzero low bits |

## Verification
The interesting collision is a taken transfer placed in the delay slot of another one: in that cycle the PC must consume the old pending target while the pending register captures the new one. The bench provokes it with a region jump followed by a taken branch, and with a jump-and-link followed by a register jump, and judges the three-cycle PC trace against targets worked out from the slot addresses. The link outputs of the call are checked in the same overlap cycle.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;

  typedef enum logic [2:0] {
    CF_NONE = 3'd0,
    CF_BEQ  = 3'd1,
    CF_BNE  = 3'd2,
    CF_BLEZ = 3'd3,
    CF_BGTZ = 3'd4,
    CF_J    = 3'd5,
    CF_JAL  = 3'd6,
    CF_JR   = 3'd7
  } cf_kind_e;

  function automatic logic is_cond_branch(cf_kind_e k);
    return (k == CF_BEQ) || (k == CF_BNE) || (k == CF_BLEZ) || (k == CF_BGTZ);
  endfunction

  function automatic logic is_region_jump(cf_kind_e k);
    return (k == CF_J) || (k == CF_JAL);
  endfunction

endpackage

// File: rtl/pcseq_cond.sv
module pcseq_cond
  import pcseq_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  cf_kind_e          kind,
  input  logic [XLEN-1:0]   rs,
  input  logic [XLEN-1:0]   rt,
  output logic              take
);

  logic eq;
  logic rs_neg;
  logic rs_zero;

  always_comb begin
    eq      = (rs == rt);
    rs_neg  = rs[XLEN-1];
    rs_zero = (rs == '0);
    unique case (kind)
      CF_BEQ:  take = eq;
      CF_BNE:  take = !eq;
      CF_BLEZ: take = rs_neg || rs_zero;
      CF_BGTZ: take = !rs_neg && !rs_zero;
      CF_J,
      CF_JAL,
      CF_JR:   take = 1'b1;
      default: take = 1'b0;
    endcase
  end

endmodule

// File: rtl/pcseq_target.sv
module pcseq_target
  import pcseq_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int IMM_B   = 16,
  parameter int IMM_J   = 26,
  parameter int ALIGN_B = 2
) (
  input  cf_kind_e          kind,
  input  logic [XLEN-1:0]   pc,
  input  logic [IMM_J-1:0]  imm,
  input  logic [XLEN-1:0]   rs,
  output logic [XLEN-1:0]   tgt,
  output logic              misalign
);

  localparam int SEXT_W = XLEN - IMM_B - ALIGN_B;
  localparam int KEEP_W = XLEN - IMM_J - ALIGN_B;
  localparam logic [XLEN-1:0] STEP = XLEN'(1 << ALIGN_B);

  logic [XLEN-1:0] slot_pc;
  logic [XLEN-1:0] br_off;
  logic [XLEN-1:0] br_tgt;
  logic [XLEN-1:0] rj_tgt;
  logic [XLEN-1:0] jr_tgt;

  assign slot_pc = pc + STEP;
  assign br_off  = {{SEXT_W{imm[IMM_B-1]}}, imm[IMM_B-1:0], {ALIGN_B{1'b0}}};
  assign br_tgt  = slot_pc + br_off;
  assign jr_tgt  = {rs[XLEN-1:ALIGN_B], {ALIGN_B{1'b0}}};

  generate
    if (KEEP_W > 0) begin : g_region_keep
      assign rj_tgt = {pc[XLEN-1 -: KEEP_W], imm, {ALIGN_B{1'b0}}};
    end else begin : g_region_full
      assign rj_tgt = XLEN'({imm, {ALIGN_B{1'b0}}});
    end
  endgenerate

  always_comb begin
    tgt      = slot_pc;
    misalign = 1'b0;
    if (is_cond_branch(kind)) begin
      tgt = br_tgt;
    end else if (is_region_jump(kind)) begin
      tgt = rj_tgt;
    end else if (kind == CF_JR) begin
      tgt      = jr_tgt;
      misalign = (rs[ALIGN_B-1:0] != '0);
    end
  end

endmodule

// File: rtl/pcseq_link.sv
module pcseq_link #(
  parameter int XLEN     = 32,
  parameter int ALIGN_B  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              is_call,
  input  logic              bad_tgt,
  input  logic [XLEN-1:0]   pc,
  output logic              we_q,
  output logic [XLEN-1:0]   val_q,
  output logic              mis_q
);

  localparam logic [XLEN-1:0] RET_OFF = XLEN'(2 << ALIGN_B);

  always_ff @(posedge clk) begin
    if (rst) begin
      we_q  <= 1'b0;
      val_q <= '0;
      mis_q <= 1'b0;
    end else begin
      we_q  <= is_call;
      mis_q <= bad_tgt;
      if (is_call) begin
        val_q <= pc + RET_OFF;
      end
    end
  end

endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
  import pcseq_pkg::*;
#(
  parameter int               XLEN     = 32,
  parameter int               IMM_B    = 16,
  parameter int               IMM_J    = 26,
  parameter int               INSN_B   = 4,
  parameter int               REG_AW   = 5,
  parameter int               LINK_REG = 31,
  parameter logic [31:0]      RESET_PC = 32'h0000_1000
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [2:0]          ctl_kind,
  input  logic [IMM_J-1:0]    ctl_imm,
  input  logic [XLEN-1:0]     rs_val,
  input  logic [XLEN-1:0]     rt_val,
  output logic [XLEN-1:0]     pc_o,
  output logic                link_we,
  output logic [REG_AW-1:0]   link_idx,
  output logic [XLEN-1:0]     link_val,
  output logic                tgt_misalign
);

  localparam int ALIGN_B = $clog2(INSN_B);
  localparam logic [XLEN-1:0] STEP = XLEN'(INSN_B);

  cf_kind_e        kind;
  logic            take;
  logic [XLEN-1:0] tgt;
  logic            tgt_bad;
  logic            pend_vld_q;
  logic [XLEN-1:0] pend_tgt_q;
  logic [XLEN-1:0] pc_q;
  logic [XLEN-1:0] pc_nxt;

  assign kind = cf_kind_e'(ctl_kind);

  pcseq_cond #(.XLEN(XLEN)) u_cond (
    .kind (kind),
    .rs   (rs_val),
    .rt   (rt_val),
    .take (take)
  );

  pcseq_target #(
    .XLEN    (XLEN),
    .IMM_B   (IMM_B),
    .IMM_J   (IMM_J),
    .ALIGN_B (ALIGN_B)
  ) u_tgt (
    .kind     (kind),
    .pc       (pc_q),
    .imm      (ctl_imm),
    .rs       (rs_val),
    .tgt      (tgt),
    .misalign (tgt_bad)
  );

  // The pending entry is consumed first; a transfer in the slot refills it.
  assign pc_nxt = pend_vld_q ? pend_tgt_q : (pc_q + STEP);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q       <= XLEN'(RESET_PC);
      pend_vld_q <= 1'b0;
      pend_tgt_q <= '0;
    end else begin
      pc_q       <= pc_nxt;
      pend_vld_q <= take;
      if (take) begin
        pend_tgt_q <= tgt;
      end
    end
  end

  pcseq_link #(.XLEN(XLEN), .ALIGN_B(ALIGN_B)) u_link (
    .clk     (clk),
    .rst     (rst),
    .is_call (kind == CF_JAL),
    .bad_tgt (tgt_bad),
    .pc      (pc_q),
    .we_q    (link_we),
    .val_q   (link_val),
    .mis_q   (tgt_misalign)
  );

  assign pc_o     = pc_q;
  assign link_idx = REG_AW'(LINK_REG);

endmodule

// File: rtl/pcseq_chk.sv
module pcseq_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst,
  input logic [2:0]      kind,
  input logic [1:0]      rs_lo,
  input logic [XLEN-1:0] pc,
  input logic            pend_v,
  input logic [XLEN-1:0] pend_t,
  input logic            lwe,
  input logic [XLEN-1:0] lval,
  input logic            mis
);

  p_pc_aligned_r2: assert property (@(posedge clk) disable iff (rst)
    pc[1:0] == 2'b00);

  p_seq_step_r2: assert property (@(posedge clk) disable iff (rst)
    !pend_v |=> pc == $past(pc) + 32'd4);

  p_redirect_r8: assert property (@(posedge clk) disable iff (rst)
    pend_v |=> pc == $past(pend_t));

  p_pend_clears_r9: assert property (@(posedge clk) disable iff (rst)
    (pend_v && kind == 3'd0) |=> !pend_v);

  p_link_r6: assert property (@(posedge clk) disable iff (rst)
    kind == 3'd6 |=> (lwe && lval == $past(pc) + 32'd8));

  p_no_link_r10: assert property (@(posedge clk) disable iff (rst)
    kind != 3'd6 |=> !lwe);

  p_misalign_r7: assert property (@(posedge clk) disable iff (rst)
    (kind == 3'd7 && rs_lo != 2'b00) |=> mis);

  p_no_misalign_r10: assert property (@(posedge clk) disable iff (rst)
    !(kind == 3'd7 && rs_lo != 2'b00) |=> !mis);

endmodule

bind pc_sequencer pcseq_chk #(.XLEN(XLEN)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .kind   (ctl_kind),
  .rs_lo  (rs_val[1:0]),
  .pc     (pc_o),
  .pend_v (pend_vld_q),
  .pend_t (pend_tgt_q),
  .lwe    (link_we),
  .lval   (link_val),
  .mis    (tgt_misalign)
);

// File: tb/sim_pc_sequencer.sv
module sim_pc_sequencer;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] RST_PC = 32'h0000_1000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  ctl_kind = 3'd0;
  logic [25:0] ctl_imm = '0;
  logic [31:0] rs_val = '0;
  logic [31:0] rt_val = '0;
  logic [31:0] pc_o;
  logic        link_we;
  logic [4:0]  link_idx;
  logic [31:0] link_val;
  logic        tgt_misalign;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pc_sequencer u0 (
    .clk          (clk),
    .rst          (rst),
    .ctl_kind     (ctl_kind),
    .ctl_imm      (ctl_imm),
    .rs_val       (rs_val),
    .rt_val       (rt_val),
    .pc_o         (pc_o),
    .link_we      (link_we),
    .link_idx     (link_idx),
    .link_val     (link_val),
    .tgt_misalign (tgt_misalign)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Presents one instruction at the current negedge, returns one cycle later.
  task automatic step(logic [2:0] k, logic [25:0] imm, logic [31:0] rs, logic [31:0] rt);
    ctl_kind = k; ctl_imm = imm; rs_val = rs; rt_val = rt;
    @(negedge clk);
    ctl_kind = 3'd0; ctl_imm = '0; rs_val = '0; rt_val = '0;
  endtask

  function automatic logic [31:0] br_t(logic [31:0] p, logic [15:0] i);
    return p + 32'd4 + {{14{i[15]}}, i, 2'b00};
  endfunction

  task automatic t_reset();
    chk("R1 pc", pc_o, RST_PC);
    chk("R1 link_we", 32'(link_we), 0);
    chk("R1 misalign", 32'(tgt_misalign), 0);
    step(3'd0, '0, '0, '0);
    chk("R1 first step", pc_o, RST_PC + 32'd4);
  endtask

  task automatic t_seq();
    for (int i = 0; i < 3; i++) begin
      logic [31:0] p = pc_o;
      step(3'd0, 26'h3ff_ffff, 32'hffff_ffff, '0);
      chk("R2 seq", pc_o, p + 32'd4);
      chk("R2 align", 32'(pc_o[1:0]), 0);
    end
  endtask

  task automatic t_branch(string req, logic [2:0] k, logic [15:0] imm,
                          logic [31:0] rs, logic [31:0] rt, bit taken);
    logic [31:0] p = pc_o;
    step(k, {10'h0, imm}, rs, rt);
    chk({req, " slot"}, pc_o, p + 32'd4);
    step(3'd0, '0, '0, '0);
    chk({req, " after"}, pc_o, taken ? br_t(p, imm) : p + 32'd8);
  endtask

  task automatic t_jr(logic [31:0] rs, bit bad);
    logic [31:0] p = pc_o;
    step(3'd7, '0, rs, '0);
    chk("R7 slot", pc_o, p + 32'd4);
    chk("R7 flag", 32'(tgt_misalign), 32'(bad));
    step(3'd0, '0, '0, '0);
    chk("R7 target", pc_o, {rs[31:2], 2'b00});
    chk("R10 flag clear", 32'(tgt_misalign), 0);
  endtask

  task automatic t_jump(logic [25:0] imm);
    logic [31:0] p = pc_o;
    step(3'd5, imm, '0, '0);
    chk("R8 slot", pc_o, p + 32'd4);
    chk("R10 no link", 32'(link_we), 0);
    step(3'd0, '0, '0, '0);
    chk("R5 target", pc_o, {p[31:28], imm, 2'b00});
  endtask

  task automatic t_jal(logic [25:0] imm);
    logic [31:0] p = pc_o;
    step(3'd6, imm, '0, '0);
    chk("R6 we", 32'(link_we), 1);
    chk("R6 idx", 32'(link_idx), 31);
    chk("R6 val", link_val, p + 32'd8);
    step(3'd0, '0, '0, '0);
    chk("R6 target", pc_o, {p[31:28], imm, 2'b00});
    chk("R10 we clear", 32'(link_we), 0);
  endtask

  task automatic t_chain_j_beq();
    logic [31:0] p = pc_o;
    logic [31:0] t1 = {p[31:28], 26'h0000800, 2'b00};
    step(3'd5, 26'h0000800, '0, '0);
    step(3'd1, 26'h0000003, 32'd9, 32'd9);
    chk("R9 first target", pc_o, t1);
    step(3'd0, '0, '0, '0);
    chk("R9 second target", pc_o, br_t(p + 32'd4, 16'd3));
    step(3'd0, '0, '0, '0);
    chk("R9 resumes", pc_o, br_t(p + 32'd4, 16'd3) + 32'd4);
  endtask

  task automatic t_chain_jal_jr();
    logic [31:0] p = pc_o;
    step(3'd6, 26'h0000400, '0, '0);
    step(3'd7, '0, 32'h0000_2222, '0);
    chk("R9 call target", pc_o, {p[31:28], 26'h0000400, 2'b00});
    chk("R6 link in overlap", link_val, p + 32'd8);
    chk("R7 flag in overlap", 32'(tgt_misalign), 1);
    step(3'd0, '0, '0, '0);
    chk("R9 jr target", pc_o, 32'h0000_2220);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 in reset", pc_o, RST_PC);
    rst = 1'b0;
    t_reset();
    t_seq();
    t_branch("R3 beq fwd", 3'd1, 16'd5, 32'd7, 32'd7, 1);
    t_branch("R3 beq back", 3'd1, 16'hfffc, 32'd1, 32'd1, 1);
    t_branch("R4 beq not", 3'd1, 16'd5, 32'd1, 32'd2, 0);
    t_branch("R4 bne taken", 3'd2, 16'd8, 32'd1, 32'd2, 1);
    t_branch("R4 bne not", 3'd2, 16'd8, 32'd4, 32'd4, 0);
    t_branch("R4 blez zero", 3'd3, 16'd2, 32'd0, 32'd5, 1);
    t_branch("R4 blez neg", 3'd3, 16'd2, 32'hffff_ffff, 32'd0, 1);
    t_branch("R4 blez pos", 3'd3, 16'd2, 32'd1, 32'd0, 0);
    t_branch("R4 bgtz pos", 3'd4, 16'd6, 32'd5, 32'd0, 1);
    t_branch("R4 bgtz min", 3'd4, 16'd6, 32'h8000_0000, 32'd0, 0);
    t_branch("R4 bgtz zero", 3'd4, 16'd6, 32'd0, 32'd0, 0);
    t_jr(32'h7000_0010, 0);
    t_jump(26'h0000040);
    t_jr(32'h0000_3002, 1);
    t_jal(26'h0000900);
    t_chain_j_beq();
    t_chain_jal_jr();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule